// File: doc/BRIEF.md
# Eight-Channel APB Countdown Timer Bank

The block holds a bank of identical 32-bit countdown timers reached over an APB slave port. Each channel owns four word registers in its own address window: a reload value, a live count, a control word and an interrupt-acknowledge location. A small shared window after the last channel holds a raw status word and a fixed version word. Once enabled, a channel decrements once per clock. When it reaches zero it reloads and latches a raw status bit. The count loaded on reload depends on the channel's mode: all ones when free-running, or the programmed reload value when periodic. Each channel drives a level interrupt, which is its raw bit gated by a per-channel mask.

The bus side is a three-state protocol machine. `AP_IDLE` goes to `AP_SETUP` on a select without enable. `AP_SETUP` goes to `AP_ACCESS` on a select with enable, and that is the single cycle in which the register effect is taken. `AP_SETUP` falls back to `AP_IDLE` if the select drops. `AP_ACCESS` goes to `AP_SETUP` when a new setup phase follows directly, and to `AP_IDLE` otherwise. Each channel runs a two-state machine. `CH_STOP` goes to `CH_RUN` on a control write with the enable bit set, and this edge copies the reload value into the counter. `CH_RUN` returns to `CH_STOP` on a control write with enable clear.

Top module: `tmr_bank_apb`

## Requirements
- R1: After reset every counter, reload value and control word is zero, every raw status bit is clear and every interrupt output is low.
- R2: `pready` is always high, so every transfer completes with no wait state. Read data is valid in the cycle where `psel` and `penable` are both high, and exactly one register effect is taken per transfer.
- R3: Channel i occupies byte addresses 20*i to 20*i+19. Its offsets are +0 reload (read/write), +4 live count (read only), +8 control (read/write) and +12 acknowledge (reads as zero). Address 0xA8 returns the raw status word, with bit i belonging to channel i. Every other address reads as zero.
- R4: The control word uses bit 0 for enable, bit 1 for mode (1 = periodic, 0 = free-running) and bit 2 for mask (1 = masked). A control write that sets enable on a stopped channel copies the reload value into the counter. A control write with enable set on a running channel does not reload it.
- R5: A running channel whose count is non-zero decrements by one each clock. A stopped channel holds its count.
- R6: A running channel whose count is zero reloads on the next clock and sets its raw status bit. In periodic mode it reloads the reload value; in free-running mode it reloads 0xFFFF_FFFF.
- R7: A reload-value write to a running channel leaves the current countdown untouched and is used at the next reload.
- R8: A channel's interrupt output equals its raw bit when unmasked and is low when masked. The raw bit still sets while masked.
- R9: Reading a channel's acknowledge location clears that channel's raw bit and no other. If a reload happens in the same cycle, the bit stays set.
- R10: Address 0xAC returns the constant given by the `VERSION` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Asynchronous active-low reset |
| paddr | input | 8 | Byte address |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| tmr_irq | output | 8 | Per-channel level interrupt |

## Verification
The properties assume well-formed APB traffic. Every transfer is a one-cycle setup phase followed by a one-cycle access phase, and `penable` is never held past the access cycle, so each acknowledge read or control write acts once. The bench drives the bus only through tasks that build exactly that two-phase shape, with random idle gaps between transfers. Reload values are kept small in the random phase so that periodic wraps, acknowledges that coincide with wraps, and free-running reloads all occur within the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // bus protocol phases seen by the slave
    typedef enum logic [1:0] {
        AP_IDLE   = 2'd0,
        AP_SETUP  = 2'd1,
        AP_ACCESS = 2'd2
    } ap_state_e;

    // channel run state
    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // register selected inside a channel window
    typedef enum logic [2:0] {
        RG_LOAD = 3'd0,
        RG_CUR  = 3'd1,
        RG_CTRL = 3'd2,
        RG_EOI  = 3'd3,
        RG_NONE = 3'd4
    } tmr_reg_e;

    // control word bit positions
    localparam int CTRL_EN   = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_MASK = 2;
    localparam int CTRL_W    = 3;

    // offsets inside the shared window
    localparam int RAW_OFS = 8;
    localparam int VER_OFS = 12;

endpackage

// File: rtl/tmr_apb_fsm.sv
module tmr_apb_fsm
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8,
    parameter int STRIDE = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    output logic                xfer_wr,
    output logic                xfer_rd,
    output logic [NUM_CH-1:0]   ch_hit,
    output tmr_reg_e            reg_sel,
    output logic                raw_hit,
    output logic                ver_hit
);

    localparam int BLK_BASE = NUM_CH * STRIDE;

    ap_state_e state_q, state_d;
    logic [ADDR_W-1:0] off;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AP_IDLE:   if (psel && !penable) state_d = AP_SETUP;
            AP_SETUP: begin
                if (psel && penable) state_d = AP_ACCESS;
                else if (!psel)      state_d = AP_IDLE;
            end
            AP_ACCESS: state_d = (psel && !penable) ? AP_SETUP : AP_IDLE;
            default:   state_d = AP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AP_IDLE;
        else        state_q <= state_d;
    end

    // outputs: a single strobe per transfer, taken on setup -> access
    always_comb begin
        xfer_wr = 1'b0;
        xfer_rd = 1'b0;
        unique case (state_q)
            AP_SETUP: begin
                xfer_wr = psel && penable && pwrite;
                xfer_rd = psel && penable && !pwrite;
            end
            default: begin
                xfer_wr = 1'b0;
                xfer_rd = 1'b0;
            end
        endcase
    end

    // channel window decode
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        localparam int LO = i * STRIDE;
        localparam int HI = (i + 1) * STRIDE;
        assign ch_hit[i] = (paddr >= ADDR_W'(LO)) && (paddr < ADDR_W'(HI));
    end

    always_comb begin
        off = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) off = paddr - ADDR_W'(i * STRIDE);
        end
    end

    always_comb begin
        unique case (off >> 2)
            ADDR_W'(0): reg_sel = RG_LOAD;
            ADDR_W'(1): reg_sel = RG_CUR;
            ADDR_W'(2): reg_sel = RG_CTRL;
            ADDR_W'(3): reg_sel = RG_EOI;
            default:    reg_sel = RG_NONE;
        endcase
    end

    assign raw_hit = (paddr == ADDR_W'(BLK_BASE + RAW_OFS));
    assign ver_hit = (paddr == ADDR_W'(BLK_BASE + VER_OFS));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic              rd_eoi,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              run_o,
    output logic              raw_o,
    output logic              irq_o
);

    ch_state_e state_q, state_d;
    logic [CNT_W-1:0] load_q, cnt_q;
    logic             mode_q, mask_q, raw_q;
    logic             start, wrap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: if (wr_ctrl && wdata[CTRL_EN])  state_d = CH_RUN;
            CH_RUN:  if (wr_ctrl && !wdata[CTRL_EN]) state_d = CH_STOP;
            default: state_d = CH_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    assign start = (state_q == CH_STOP) && wr_ctrl && wdata[CTRL_EN];
    assign wrap  = (state_q == CH_RUN) && (cnt_q == '0);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            cnt_q  <= '0;
            mode_q <= 1'b0;
            mask_q <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) begin
                mode_q <= wdata[CTRL_MODE];
                mask_q <= wdata[CTRL_MASK];
            end
            unique case (state_q)
                CH_STOP: if (start) cnt_q <= load_q;
                CH_RUN: begin
                    if (wrap) cnt_q <= mode_q ? load_q : '1;
                    else      cnt_q <= cnt_q - CNT_W'(1);
                end
                default: cnt_q <= cnt_q;
            endcase
            if (wrap)        raw_q <= 1'b1;
            else if (rd_eoi) raw_q <= 1'b0;
        end
    end

    assign load_o = load_q;
    assign cnt_o  = cnt_q;
    assign run_o  = (state_q == CH_RUN);
    assign ctrl_o = {mask_q, mode_q, run_o};
    assign raw_o  = raw_q;
    assign irq_o  = raw_q && !mask_q;

endmodule

// File: rtl/tmr_bank_apb.sv
module tmr_bank_apb
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 8,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 8,
    parameter int          STRIDE  = 20,
    parameter logic [31:0] VERSION = 32'h0107_2A11
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              pready,
    output logic [NUM_CH-1:0] tmr_irq
);

    logic                          xfer_wr, xfer_rd, raw_hit, ver_hit;
    logic [NUM_CH-1:0]             ch_hit;
    tmr_reg_e                      reg_sel;
    logic [NUM_CH-1:0]             wr_load, wr_ctrl, rd_eoi, run_vec, raw_vec;
    logic [NUM_CH-1:0]             mode_vec;
    logic [NUM_CH-1:0][CNT_W-1:0]  load_vec, cnt_vec;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_vec;

    tmr_apb_fsm #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .STRIDE (STRIDE)
    ) u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .xfer_wr (xfer_wr),
        .xfer_rd (xfer_rd),
        .ch_hit  (ch_hit),
        .reg_sel (reg_sel),
        .raw_hit (raw_hit),
        .ver_hit (ver_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign wr_load[i] = xfer_wr && ch_hit[i] && (reg_sel == RG_LOAD);
        assign wr_ctrl[i] = xfer_wr && ch_hit[i] && (reg_sel == RG_CTRL);
        assign rd_eoi[i]  = xfer_rd && ch_hit[i] && (reg_sel == RG_EOI);
        assign mode_vec[i] = ctrl_vec[i][CTRL_MODE];

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_load (wr_load[i]),
            .wr_ctrl (wr_ctrl[i]),
            .rd_eoi  (rd_eoi[i]),
            .wdata   (pwdata),
            .load_o  (load_vec[i]),
            .cnt_o   (cnt_vec[i]),
            .ctrl_o  (ctrl_vec[i]),
            .run_o   (run_vec[i]),
            .raw_o   (raw_vec[i]),
            .irq_o   (tmr_irq[i])
        );
    end

    // read mux
    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
                unique case (reg_sel)
                    RG_LOAD: prdata = load_vec[i];
                    RG_CUR:  prdata = cnt_vec[i];
                    RG_CTRL: prdata = CNT_W'(ctrl_vec[i]);
                    default: prdata = '0;
                endcase
            end
        end
        if (raw_hit) prdata = CNT_W'(raw_vec);
        if (ver_hit) prdata = CNT_W'(VERSION);
    end

    assign pready = 1'b1;

endmodule

// File: rtl/tmr_bank_apb_chk.sv
module tmr_bank_apb_chk #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            run_vec,
    input logic [NUM_CH-1:0]            mode_vec,
    input logic [NUM_CH-1:0]            raw_vec,
    input logic [NUM_CH-1:0]            wr_ctrl,
    input logic [NUM_CH-1:0]            rd_eoi,
    input logic                         wen_bit,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] load_vec
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        assert_start_copies_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl[i] && wen_bit && !run_vec[i]) |=> (cnt_vec[i] == $past(load_vec[i])));

        assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !wr_ctrl[i]) |=> $stable(cnt_vec[i]));

        assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] && cnt_vec[i] != '0) |=> (cnt_vec[i] == $past(cnt_vec[i]) - CNT_W'(1)));

        assert_wrap_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] && cnt_vec[i] == '0) |=> raw_vec[i]);

        assert_free_reload_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] && cnt_vec[i] == '0 && !mode_vec[i]) |=> (&cnt_vec[i]));

        assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_eoi[i] && !(run_vec[i] && cnt_vec[i] == '0)) |=> !raw_vec[i]);
    end

    assert_single_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_eoi));

endmodule

bind tmr_bank_apb tmr_bank_apb_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (pclk),
    .rst_n    (presetn),
    .run_vec  (run_vec),
    .mode_vec (mode_vec),
    .raw_vec  (raw_vec),
    .wr_ctrl  (wr_ctrl),
    .rd_eoi   (rd_eoi),
    .wen_bit  (pwdata[0]),
    .cnt_vec  (cnt_vec),
    .load_vec (load_vec)
);

// File: tb/tmr_bank_apb_bench.sv
`timescale 1ns/1ps
module tmr_bank_apb_bench;

    localparam int          N   = 8;
    localparam int          W   = 32;
    localparam int          AW  = 8;
    localparam int          STR = 20;
    localparam logic [31:0] VER = 32'h0107_2A11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [W-1:0]  pwdata = '0;
    logic [W-1:0]  prdata;
    logic          pready;
    logic [N-1:0]  tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_bank_apb #(
        .NUM_CH (N), .CNT_W (W), .ADDR_W (AW), .STRIDE (STR), .VERSION (VER)
    ) u_tmr_bank_apb (
        .pclk (clk), .presetn (rst_n), .paddr (paddr), .psel (psel),
        .penable (penable), .pwrite (pwrite), .pwdata (pwdata),
        .prdata (prdata), .pready (pready), .tmr_irq (tmr_irq)
    );

    // reference model built from the requirements
    logic [W-1:0] m_cnt [N];
    logic [W-1:0] m_load[N];
    logic         m_en[N], m_mode[N], m_mask[N], m_raw[N];

    function automatic int ch_of(input logic [AW-1:0] a);
        if (int'(a) < N * STR) return int'(a) / STR;
        return -1;
    endfunction

    function automatic int idx_of(input logic [AW-1:0] a);
        return (int'(a) % STR) / 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] <= '0; m_load[i] <= '0; m_en[i] <= 1'b0;
                m_mode[i] <= 1'b0; m_mask[i] <= 1'b0; m_raw[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (psel && penable && pwrite && ch_of(paddr) == i && idx_of(paddr) == 2
                    && pwdata[0] && !m_en[i])
                    m_cnt[i] <= m_load[i];
                else if (m_en[i])
                    m_cnt[i] <= (m_cnt[i] == '0) ? (m_mode[i] ? m_load[i] : '1)
                                                 : m_cnt[i] - 1;
                if (m_en[i] && m_cnt[i] == '0)
                    m_raw[i] <= 1'b1;
                else if (psel && penable && !pwrite && ch_of(paddr) == i && idx_of(paddr) == 3)
                    m_raw[i] <= 1'b0;
                if (psel && penable && pwrite && ch_of(paddr) == i && idx_of(paddr) == 2) begin
                    m_en[i] <= pwdata[0]; m_mode[i] <= pwdata[1]; m_mask[i] <= pwdata[2];
                end
                if (psel && penable && pwrite && ch_of(paddr) == i && idx_of(paddr) == 0)
                    m_load[i] <= pwdata;
            end
        end
    end

    function automatic logic [W-1:0] exp_rd(input logic [AW-1:0] a);
        int c;
        logic [W-1:0] r;
        c = ch_of(a);
        r = '0;
        if (c >= 0) begin
            case (idx_of(a))
                0: r = m_load[c];
                1: r = m_cnt[c];
                2: r = {29'b0, m_mask[c], m_mode[c], m_en[c]};
                default: r = '0;
            endcase
        end else if (int'(a) == N * STR + 8) begin
            for (int i = 0; i < N; i++) r[i] = m_raw[i];
        end else if (int'(a) == N * STR + 12) begin
            r = VER;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_raw[i] && !m_mask[i];
        return v;
    endfunction

    task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [W-1:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = AW'(a); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input int a, input string tag);
        logic [W-1:0] e;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = AW'(a);
        @(negedge clk);
        penable = 1'b1;
        #1;
        e = exp_rd(AW'(a));
        check(W'(pready), W'(1), "R2");
        check(prdata, e, tag);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        #1;
        check(W'(tmr_irq), W'(exp_irq()), tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle(4);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk("R1");
        check(W'(tmr_irq), '0, "R1");
        bus_rd(0 * STR + 8, "R1");
        bus_rd(7 * STR + 4, "R1");
        bus_rd(5 * STR + 0, "R1");
        bus_rd(N * STR + 8, "R1");
        // R10 version, R3 unmapped
        bus_rd(N * STR + 12, "R10");
        bus_rd(N * STR + 0, "R3");
        bus_rd(N * STR + 16, "R3");
        bus_rd(2 * STR + 16, "R3");
        // R4 start copies reload, rewriting enable does not reload
        bus_wr(0 * STR + 0, 32'd100);
        bus_wr(0 * STR + 8, 32'h3);
        bus_rd(0 * STR + 4, "R4");
        idle(5);
        bus_wr(0 * STR + 8, 32'h3);
        bus_rd(0 * STR + 4, "R4");
        bus_rd(0 * STR + 8, "R4");
        // R6 periodic wrap
        bus_wr(2 * STR + 0, 32'd6);
        bus_wr(2 * STR + 8, 32'h3);
        idle(20);
        bus_rd(N * STR + 8, "R6");
        irq_chk("R8");
        bus_rd(2 * STR + 4, "R6");
        // R8 masked free-running
        bus_wr(4 * STR + 0, 32'd3);
        bus_wr(4 * STR + 8, 32'h5);
        idle(10);
        irq_chk("R8");
        bus_rd(N * STR + 8, "R8");
        bus_rd(4 * STR + 4, "R6");
        // R9 ack clears own channel only
        bus_wr(2 * STR + 8, 32'h0);
        bus_rd(2 * STR + 12, "R9");
        bus_rd(N * STR + 8, "R9");
        irq_chk("R9");
        // R5 stopped channel holds
        bus_wr(0 * STR + 8, 32'h0);
        bus_rd(0 * STR + 4, "R5");
        idle(7);
        bus_rd(0 * STR + 4, "R5");
        // R7 reload change while running
        bus_wr(1 * STR + 0, 32'd12);
        bus_wr(1 * STR + 8, 32'h3);
        bus_wr(1 * STR + 0, 32'd5);
        bus_rd(1 * STR + 4, "R7");
        idle(14);
        bus_rd(1 * STR + 4, "R7");
        // random traffic
        for (int k = 0; k < 400; k++) begin
            int c;
            int op;
            c  = int'($urandom % N);
            op = int'($urandom % 6);
            case (op)
                0: bus_wr(c * STR + 0, W'($urandom % 50));
                1: bus_wr(c * STR + 8, W'($urandom % 8));
                5: bus_rd(N * STR + 8, "R6");
                default: bus_rd(c * STR + 4 * int'($urandom % 4), "R3");
            endcase
            idle(int'($urandom % 8));
            irq_chk("R8");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule